// File: doc/BRIEF.md
# Indirect Filter Configuration Window

This block gives a host bus access to a bank of per-filter configuration words for layer-3/layer-4 packet filters. The words are not mapped directly. Software reaches them through two registers: a window control register and a window data register. The control register names a filter, a word index inside that filter, and a direction. Setting its busy bit starts a transfer.

For a store, software first loads the data register and then writes the control register with busy set. When busy clears, the data register's contents are in the selected word. For a fetch, software writes the control register with busy set and direction set to read. Once busy clears, the data register holds the selected word. A read-only capability register reports how many filters are implemented. Each filter holds eight words: index 0 is its control word, index 1 its layer-4 port word, and indices 4 to 7 its layer-3 address words.

Top module: `l34_filt_access`

## Requirements
- R1: After reset, the control register, the data register and every filter word read as zero.
- R2: The control register layout is as follows. Bits 15:12 hold the filter number and bits 11:8 the word index, so bits 15:8 equal filter*16+index. Bit 1 is the direction (1 = fetch from the bank, 0 = store to the bank) and bit 0 is busy. All other bits read as zero.
- R3: A control write accepted with bit 0 set sets busy. Busy clears exactly XFER_LAT (default 3) clocks later. A control write with bit 0 clear only updates the stored fields and starts no transfer.
- R4: A store transfer copies the data register into the selected word.
- R5: A fetch transfer loads the selected word into the data register, and the new value is visible from the cycle in which busy reads clear. The stored fields stay in the control register.
- R6: Writes to the control register while busy is set are ignored.
- R7: Writes to the data register while busy is set are ignored.
- R8: A transfer that names a filter number at or above NUM_FILT, or an index of 8 or above, still completes in XFER_LAT clocks. A fetch then returns zero, and a store changes no word.
- R9: The capability register at offset 0xC08 reads NUM_FILT in bits 30:27 and zero elsewhere. Writes to it have no effect.
- R10: The control register is at offset 0xC00 and the data register at 0xC04. rd_data_o is registered: it shows the addressed register one clock after rd_en_i and holds otherwise. Unmapped offsets read as zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Host write strobe |
| wr_addr_i | input | 12 | Host write byte offset |
| wr_data_i | input | 32 | Host write data |
| rd_en_i | input | 1 | Host read strobe |
| rd_addr_i | input | 12 | Host read byte offset |
| rd_data_o | output | 32 | Registered host read data |

## Verification
A host read issued on one edge returns data in the following cycle. A control write that starts a transfer is therefore seen as busy by exactly XFER_LAT consecutive back-to-back polls, and the first poll that reads busy clear is also the first cycle in which a fetched word can be read from the data register. The bench drives every host access at the falling edge and samples rd_data_o at the next falling edge. A behavioural model updated on each rising edge predicts rd_data_o one cycle ahead, and its prediction is compared in every cycle. Scripted checks then count busy polls and read back words after each transfer, using literal expected values.

// File: rtl/l34_filt_pkg.sv
package l34_filt_pkg;
  localparam int unsigned HOST_AW = 12;
  localparam int unsigned WORD_W  = 32;
  localparam int unsigned SEL_W   = 4;
  localparam int unsigned IDX_W   = 4;
  localparam int unsigned CAPS_LSB = 27;
  localparam int unsigned CAPS_W   = 4;

  localparam logic [HOST_AW-1:0] OFS_CTRL = 12'hC00;
  localparam logic [HOST_AW-1:0] OFS_DATA = 12'hC04;
  localparam logic [HOST_AW-1:0] OFS_CAPS = 12'hC08;

  typedef struct packed {
    logic [SEL_W-1:0] fsel;
    logic [IDX_W-1:0] idx;
    logic             dir_rd;
    logic             busy;
  } win_ctrl_t;

  function automatic logic [WORD_W-1:0] ctrl_to_word(win_ctrl_t c);
    return {16'h0, c.fsel, c.idx, 6'h0, c.dir_rd, c.busy};
  endfunction
endpackage

// File: rtl/l34_filt_window.sv
module l34_filt_window
  import l34_filt_pkg::*;
#(
  parameter int unsigned XFER_LAT = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ctrl_we_i,
  input  logic              data_we_i,
  input  logic [WORD_W-1:0] wdata_i,
  input  logic [WORD_W-1:0] bank_rdata_i,
  output win_ctrl_t         ctrl_o,
  output logic [WORD_W-1:0] data_o,
  output logic              done_o
);
  localparam int unsigned CNT_W = $clog2(XFER_LAT + 1);

  logic [CNT_W-1:0]  cnt_q;
  win_ctrl_t         ctrl_q;
  logic [WORD_W-1:0] data_q;
  logic              unused_wbits;

  assign unused_wbits = ^{wdata_i[31:16], wdata_i[7:2]};
  assign done_o = ctrl_q.busy && (cnt_q == CNT_W'(XFER_LAT - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      ctrl_q <= '0;
      data_q <= '0;
    end else if (ctrl_q.busy) begin
      // host writes are locked out until the transfer ends
      if (done_o) begin
        ctrl_q.busy <= 1'b0;
        if (ctrl_q.dir_rd) data_q <= bank_rdata_i;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end else begin
      if (ctrl_we_i) begin
        ctrl_q.fsel   <= wdata_i[15:12];
        ctrl_q.idx    <= wdata_i[11:8];
        ctrl_q.dir_rd <= wdata_i[1];
        ctrl_q.busy   <= wdata_i[0];
        cnt_q         <= '0;
      end
      if (data_we_i) data_q <= wdata_i;
    end
  end

  assign ctrl_o = ctrl_q;
  assign data_o = data_q;

  assert_busy_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_q.busy && !done_o |=> ctrl_q.busy);
  assert_busy_drop_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !ctrl_q.busy);
  assert_ctrl_locked_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_q.busy && ctrl_we_i |=> $stable(ctrl_q.fsel) && $stable(ctrl_q.idx) && $stable(ctrl_q.dir_rd));
  assert_data_locked_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_q.busy && !(done_o && ctrl_q.dir_rd) |=> $stable(data_q));
endmodule

// File: rtl/l34_filt_bank.sv
module l34_filt_bank
  import l34_filt_pkg::*;
#(
  parameter int unsigned NUM_FILT       = 4,
  parameter int unsigned WORDS_PER_FILT = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [SEL_W-1:0]  fsel_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [WORD_W-1:0] wdata_i,
  output logic [WORD_W-1:0] rdata_o
);
  localparam int unsigned SLOT_W = $clog2(WORDS_PER_FILT);

  logic [WORD_W-1:0] filt_rd [NUM_FILT];
  logic              idx_ok;

  assign idx_ok = (32'(idx_i) < WORDS_PER_FILT);

  for (genvar g = 0; g < NUM_FILT; g++) begin : g_filt
    logic [WORD_W-1:0] words_q [WORDS_PER_FILT];
    logic              hit;

    assign hit = we_i && idx_ok && (32'(fsel_i) == g);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        for (int w = 0; w < WORDS_PER_FILT; w++) words_q[w] <= '0;
      end else if (hit) begin
        words_q[idx_i[SLOT_W-1:0]] <= wdata_i;
      end
    end

    assign filt_rd[g] = words_q[idx_i[SLOT_W-1:0]];
  end

  always_comb begin
    rdata_o = '0;
    for (int k = 0; k < NUM_FILT; k++) begin
      if (idx_ok && (32'(fsel_i) == k)) rdata_o = filt_rd[k];
    end
  end
endmodule

// File: rtl/l34_filt_access.sv
module l34_filt_access
  import l34_filt_pkg::*;
#(
  parameter int unsigned NUM_FILT       = 4,
  parameter int unsigned WORDS_PER_FILT = 8,
  parameter int unsigned XFER_LAT       = 3
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_en_i,
  input  logic [HOST_AW-1:0] wr_addr_i,
  input  logic [WORD_W-1:0]  wr_data_i,
  input  logic               rd_en_i,
  input  logic [HOST_AW-1:0] rd_addr_i,
  output logic [WORD_W-1:0]  rd_data_o
);
  localparam logic [WORD_W-1:0] CAPS_WORD =
    {{(WORD_W-CAPS_LSB-CAPS_W){1'b0}}, CAPS_W'(NUM_FILT), {CAPS_LSB{1'b0}}};

  win_ctrl_t         ctrl;
  logic [WORD_W-1:0] data;
  logic [WORD_W-1:0] bank_rdata;
  logic [WORD_W-1:0] rd_mux;
  logic [WORD_W-1:0] rd_q;
  logic              done;
  logic              ctrl_we;
  logic              data_we;
  logic              bank_we;

  assign ctrl_we = wr_en_i && (wr_addr_i == OFS_CTRL);
  assign data_we = wr_en_i && (wr_addr_i == OFS_DATA);
  assign bank_we = done && !ctrl.dir_rd;

  l34_filt_window #(.XFER_LAT(XFER_LAT)) u_window (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .ctrl_we_i    (ctrl_we),
    .data_we_i    (data_we),
    .wdata_i      (wr_data_i),
    .bank_rdata_i (bank_rdata),
    .ctrl_o       (ctrl),
    .data_o       (data),
    .done_o       (done)
  );

  l34_filt_bank #(.NUM_FILT(NUM_FILT), .WORDS_PER_FILT(WORDS_PER_FILT)) u_bank (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (bank_we),
    .fsel_i  (ctrl.fsel),
    .idx_i   (ctrl.idx),
    .wdata_i (data),
    .rdata_o (bank_rdata)
  );

  always_comb begin
    unique case (rd_addr_i)
      OFS_CTRL: rd_mux = ctrl_to_word(ctrl);
      OFS_DATA: rd_mux = data;
      OFS_CAPS: rd_mux = CAPS_WORD;
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      rd_q <= '0;
    else if (rd_en_i) rd_q <= rd_mux;
  end

  assign rd_data_o = rd_q;

  assert_wr_lands_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bank_we && (32'(ctrl.fsel) < NUM_FILT) && (32'(ctrl.idx) < WORDS_PER_FILT)
    |=> bank_rdata == $past(data));
  assert_rd_loads_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done && ctrl.dir_rd |=> data == $past(bank_rdata));
  assert_oor_fetch_zero_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done && ctrl.dir_rd && (32'(ctrl.fsel) >= NUM_FILT) |=> data == '0);
  assert_caps_field_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_en_i && (rd_addr_i == OFS_CAPS) |=> 32'(rd_data_o[CAPS_LSB +: CAPS_W]) == NUM_FILT);
endmodule

// File: tb/l34_filt_access_tb_top.sv
module l34_filt_access_tb_top;
  import l34_filt_pkg::*;

  localparam int NF  = 4;
  localparam int NW  = 8;
  localparam int LAT = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [11:0] wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic        rd_en = 1'b0;
  logic [11:0] rd_addr = '0;
  logic [31:0] rd_data;
  logic        fin = 1'b0;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  l34_filt_access #(.NUM_FILT(NF), .WORDS_PER_FILT(NW), .XFER_LAT(LAT)) dut_i (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .wr_en_i   (wr_en),
    .wr_addr_i (wr_addr),
    .wr_data_i (wr_data),
    .rd_en_i   (rd_en),
    .rd_addr_i (rd_addr),
    .rd_data_o (rd_data)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  // behavioural reference model
  logic [31:0] m_mem [16][16];
  logic [3:0]  m_f, m_i;
  logic        m_dir, m_busy;
  int          m_left;
  logic [31:0] m_data, m_rd;

  function automatic logic [31:0] m_look();
    return (m_f < NF && m_i < NW) ? m_mem[m_f][m_i] : 32'h0;
  endfunction

  function automatic logic [31:0] m_reg(input logic [11:0] a);
    case (a)
      12'hC00: return {16'h0, m_f, m_i, 6'h0, m_dir, m_busy};
      12'hC04: return m_data;
      12'hC08: return 32'(NF) << 27;
      default: return 32'h0;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int a = 0; a < 16; a++) for (int b = 0; b < 16; b++) m_mem[a][b] = '0;
      m_f = '0; m_i = '0; m_dir = 1'b0; m_busy = 1'b0; m_left = 0;
      m_data = '0; m_rd = '0;
    end else begin
      if (rd_en) m_rd = m_reg(rd_addr);
      if (m_busy) begin
        m_left--;
        if (m_left == 0) begin
          m_busy = 1'b0;
          if (m_dir) m_data = m_look();
          else if (m_f < NF && m_i < NW) m_mem[m_f][m_i] = m_data;
        end
      end else begin
        if (wr_en && wr_addr == 12'hC00) begin
          m_f = wr_data[15:12]; m_i = wr_data[11:8];
          m_dir = wr_data[1]; m_busy = wr_data[0]; m_left = LAT;
        end
        if (wr_en && wr_addr == 12'hC04) m_data = wr_data;
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && !fin) chk("R10 per-cycle model", rd_data, m_rd);
  end

  // host tasks: entered and left at a falling edge
  task automatic bus_wr(input logic [11:0] a, input logic [31:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic bus_rd(input logic [11:0] a, output logic [31:0] d);
    rd_en = 1'b1; rd_addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    d = rd_data;
  endtask

  function automatic logic [31:0] ctl(input int f, input int i, input bit rd, input bit go);
    return (32'(f) << 12) | (32'(i) << 8) | (32'(rd) << 1) | 32'(go);
  endfunction

  function automatic logic [31:0] pat(input int f, input int i);
    return 32'hC0DE_0000 | (32'(f) << 8) | 32'(i);
  endfunction

  task automatic wait_idle(output int n);
    logic [31:0] v;
    n = 0;
    do begin
      bus_rd(12'hC00, v);
      if (v[0]) n++;
    end while (v[0] && n < 50);
  endtask

  task automatic xfer_wr(input int f, input int i, input logic [31:0] val);
    int n;
    bus_wr(12'hC04, val);
    bus_wr(12'hC00, ctl(f, i, 1'b0, 1'b1));
    wait_idle(n);
  endtask

  task automatic xfer_rd(input int f, input int i, output logic [31:0] val);
    int n;
    bus_wr(12'hC00, ctl(f, i, 1'b1, 1'b1));
    wait_idle(n);
    bus_rd(12'hC04, val);
  endtask

  initial begin
    logic [31:0] v;
    int n;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    bus_rd(12'hC00, v); chk("R1 ctrl after reset", v, 32'h0);
    bus_rd(12'hC04, v); chk("R1 data after reset", v, 32'h0);
    xfer_rd(3, 7, v);   chk("R1 filter word after reset", v, 32'h0);

    // R9 capability field
    bus_rd(12'hC08, v); chk("R9 caps", v, 32'h2000_0000);

    // R3 busy length
    bus_wr(12'hC04, 32'h5555_AAAA);
    bus_wr(12'hC00, ctl(0, 0, 1'b0, 1'b1));
    wait_idle(n); chk("R3 busy polls", 32'(n), 32'(LAT));

    // R4 / R5 fill and read back
    for (int f = 0; f < NF; f++)
      for (int i = 0; i < NW; i++)
        if (i != 2 && i != 3) xfer_wr(f, i, pat(f, i));
    for (int f = 0; f < NF; f++)
      for (int i = 0; i < NW; i++)
        if (i != 2 && i != 3) begin
          xfer_rd(f, i, v); chk("R4 R5 word readback", v, pat(f, i));
        end
    bus_rd(12'hC00, v); chk("R5 ctrl keeps fields", v, ctl(3, 7, 1'b1, 1'b0));

    // R2 layout and unused bits
    bus_wr(12'hC04, 32'h0BAD_F00D);
    bus_wr(12'hC00, 32'hFFFF_FFFE);
    bus_rd(12'hC00, v); chk("R2 ctrl layout", v, 32'h0000_FF02);
    bus_rd(12'hC04, v); chk("R3 no-go leaves data", v, 32'h0BAD_F00D);

    // R3 write without busy bit starts nothing
    bus_wr(12'hC00, ctl(1, 4, 1'b0, 1'b0));
    repeat (LAT + 2) @(negedge clk);
    xfer_rd(1, 4, v); chk("R3 no-go leaves word", v, pat(1, 4));

    // R6 control write while busy
    bus_wr(12'hC04, 32'h1111_2222);
    bus_wr(12'hC00, ctl(0, 1, 1'b0, 1'b1));
    bus_wr(12'hC00, ctl(2, 6, 1'b1, 1'b1));
    wait_idle(n);
    bus_rd(12'hC00, v); chk("R6 ctrl ignored while busy", v, ctl(0, 1, 1'b0, 1'b0));
    xfer_rd(2, 6, v);   chk("R6 other word untouched", v, pat(2, 6));
    xfer_rd(0, 1, v);   chk("R6 original target stored", v, 32'h1111_2222);

    // R7 data write while busy
    bus_wr(12'hC04, 32'hAAAA_0001);
    bus_wr(12'hC00, ctl(3, 4, 1'b0, 1'b1));
    bus_wr(12'hC04, 32'hBBBB_0002);
    wait_idle(n);
    xfer_rd(3, 4, v); chk("R7 store uses pre-busy data", v, 32'hAAAA_0001);
    bus_wr(12'hC00, ctl(1, 0, 1'b1, 1'b1));
    bus_wr(12'hC04, 32'hDEAD_BEEF);
    wait_idle(n);
    bus_rd(12'hC04, v); chk("R7 fetch not overwritten", v, pat(1, 0));

    // R8 out-of-range filter and index
    bus_wr(12'hC04, 32'h7777_7777);
    bus_wr(12'hC00, ctl(4, 0, 1'b0, 1'b1));
    wait_idle(n); chk("R8 oor busy polls", 32'(n), 32'(LAT));
    xfer_rd(4, 0, v);  chk("R8 oor filter fetch", v, 32'h0);
    xfer_wr(0, 9, 32'h9999_9999);
    xfer_rd(0, 9, v);  chk("R8 oor index fetch", v, 32'h0);
    xfer_rd(15, 1, v); chk("R8 top filter fetch", v, 32'h0);
    xfer_rd(0, 0, v);  chk("R8 no aliasing", v, pat(0, 0));
    xfer_rd(0, 1, v);  chk("R8 no aliasing idx1", v, 32'h1111_2222);

    // R9 caps write ignored, R10 unmapped
    bus_wr(12'hC08, 32'h0);
    bus_rd(12'hC08, v); chk("R9 caps after write", v, 32'h2000_0000);
    bus_rd(12'h004, v); chk("R10 unmapped low", v, 32'h0);
    bus_rd(12'hC0C, v); chk("R10 unmapped high", v, 32'h0);
    repeat (2) @(negedge clk);
    chk("R10 read data holds", rd_data, 32'h0);

    fin = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    fin = 1'b1;
    checks++; fails++;
    $display("FAIL R3 watchdog got=hung exp=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule